// File: doc/BRIEF.md
# Maskable interrupt status controller

This block collects single-cycle event pulses from up to eleven peripheral sources and keeps each one as a pending bit in a 16-bit status register. A 16-bit enable mask decides which pending bits reach the processor. The block drives one level-sensitive request line, which is high whenever a pending bit is also enabled. Source 3 is wired to the DMA controller's interrupt.

Software reaches both registers over a small register bus with 32-bit data. A write carries a valid strobe and a write strobe in the same cycle. Read data appears one cycle after the read request. To acknowledge events, software writes to the status register. The write keeps only the bits that are set in the written value, so a 0 clears a bit and a 1 leaves it as it was. A write to the mask register replaces the mask. After either write the request line is evaluated again right away. If software unmasks a bit that is already pending, the request rises at once and does not wait for a new event.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the status register, the mask register, `irq_req` and `bus_rdata` are all zero.
- R2: A pulse on `src_pulse[i]` sets status bit i at the next clock edge. The bit then stays set until software acknowledges it. Bit 3 is the DMA-controller source.
- R3: A write to offset 0x070 replaces the status register with the bitwise AND of its current value and `bus_wdata[15:0]`.
- R4: A write to offset 0x074 replaces the whole mask register with `bus_wdata[15:0]`. With no write to that offset, the mask holds its value.
- R5: One cycle after any pulse, status write or mask write, `irq_req` equals the OR-reduction of (status AND mask).
- R6: A mask write that enables a bit which is already pending raises `irq_req` at the next edge, with no new pulse.
- R7: If a source pulse arrives in the same cycle as a status write that would clear its bit, the bit stays set.
- R8: `bus_wdata[31:16]` has no effect on either register, and `bus_rdata[31:16]` always reads zero.
- R9: A read (valid high, write low) loads `bus_rdata` at the next edge with the addressed register: 0x070 gives status, 0x074 gives mask, and any other offset gives zero. Between reads, `bus_rdata` holds its value. Writes to other offsets change nothing.
- R10: Status bits at and above the number of sources (bits 11 to 15) always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 11 | One-cycle event pulses, one per source |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read, qualified by bus_valid |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Level interrupt request to the CPU |

## Verification
An incoming source pulse and an acknowledge write to the status register can land in the same cycle, and both try to change the same status bit. The bench provokes this in a directed test: it raises a source pulse while writing a 0 to that source's bit. It also lets random traffic pair pulses with acknowledges of every bit pattern. A bench model updates status as (old AND written) OR pulses. The bench judges the outcome by reading the status register back and by watching `irq_req` the cycle after. The set must win.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DEF_REG_W  = 16;
  localparam int DEF_BUS_W  = 32;
  localparam int DEF_ADDR_W = 12;
  localparam int DEF_NSRC   = 11;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NUM_SRC = 11,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               ack_en,
  input  logic [REG_W-1:0]   ack_data,
  output logic [REG_W-1:0]   status_q,
  output logic [REG_W-1:0]   status_nxt
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b < NUM_SRC) begin : g_src
      logic bit_q;
      logic bit_d;
      // a pulse sets the bit; an acknowledge may only clear the old value
      assign bit_d = src_pulse[b] | (bit_q & ~(ack_en & ~ack_data[b]));
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
      end
      assign status_q[b]   = bit_q;
      assign status_nxt[b] = bit_d;

      AST_SRC_SETS: assert property (@(posedge clk) disable iff (rst)
        src_pulse[b] |=> status_q[b]); // R2
      AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (src_pulse[b] && ack_en && !ack_data[b]) |=> status_q[b]); // R7
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_en && !ack_data[b] && !src_pulse[b]) |=> !status_q[b]); // R3
      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_en && !src_pulse[b]) |=> status_q[b] == $past(status_q[b])); // R2
    end else begin : g_spare
      assign status_q[b]   = 1'b0;
      assign status_nxt[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] mask_nxt
);
  assign mask_nxt = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mask_q == $past(wr_data)); // R4
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q)); // R4
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_ctrl_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] status_q,
  input  logic [REG_W-1:0] mask_q,
  output logic [BUS_W-1:0] rdata
);
  logic [REG_W-1:0] pick;
  logic [BUS_W-1:0] word;

  always_comb begin
    unique case (sel)
      SEL_STATUS: pick = status_q;
      SEL_MASK:   pick = mask_q;
      default:    pick = '0;
    endcase
    word            = '0;
    word[REG_W-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end

  AST_RD_STATUS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_STATUS) |=> rdata[REG_W-1:0] == $past(status_q)); // R9
  AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_MASK) |=> rdata[REG_W-1:0] == $past(mask_q)); // R9
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = DEF_NSRC,
  parameter int REG_W   = DEF_REG_W,
  parameter int BUS_W   = DEF_BUS_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h074
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_req
);
  reg_sel_e         sel;
  logic             stat_wr, mask_wr, rd_en;
  logic [REG_W-1:0] wdata_lo;
  logic [REG_W-1:0] status_q, status_nxt, mask_q, mask_nxt;
  logic             irq_q;

  always_comb begin
    if (bus_addr == STATUS_OFS)    sel = SEL_STATUS;
    else if (bus_addr == MASK_OFS) sel = SEL_MASK;
    else                           sel = SEL_NONE;
  end

  assign stat_wr  = bus_valid & bus_write & (sel == SEL_STATUS);
  assign mask_wr  = bus_valid & bus_write & (sel == SEL_MASK);
  assign rd_en    = bus_valid & ~bus_write;
  assign wdata_lo = bus_wdata[REG_W-1:0];

  irq_pending_bank #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_pend (
    .clk(clk), .rst(rst), .src_pulse(src_pulse),
    .ack_en(stat_wr), .ack_data(wdata_lo),
    .status_q(status_q), .status_nxt(status_nxt));

  irq_enable_reg #(.REG_W(REG_W)) u_mask (
    .clk(clk), .rst(rst), .wr_en(mask_wr), .wr_data(wdata_lo),
    .mask_q(mask_q), .mask_nxt(mask_nxt));

  irq_readback #(.REG_W(REG_W), .BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
    .status_q(status_q), .mask_q(mask_q), .rdata(bus_rdata));

  // request register tracks the state both registers take at this edge
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_nxt & mask_nxt);
  end
  assign irq_req = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_req == |(status_q & mask_q)); // R5
  AST_UNMASK_RAISE: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && |(status_q & wdata_lo)) |=> irq_req); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!irq_req && status_q == '0 && mask_q == '0)); // R1
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 11;
  localparam logic [11:0] A_ST = 12'h070;
  localparam logic [11:0] A_MK = 12'h074;
  localparam logic [11:0] A_XX = 12'h078;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] src_pulse;
  logic            bus_valid, bus_write;
  logic [11:0]     bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_req;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_st, m_mk;
  logic [31:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req));

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a == A_ST)      return {16'h0, m_st};
    else if (a == A_MK) return {16'h0, m_mk};
    else                return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; drives away from the edge, checks one step after it
  task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d,
                      logic [NSRC-1:0] p, string req);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; src_pulse = p;
    if (v && !w) m_rd = exp_read(a);
    @(posedge clk); #1;
    if (v && w && a == A_ST) m_st = m_st & d[15:0];
    m_st = m_st | {5'h0, p};
    if (v && w && a == A_MK) m_mk = d[15:0];
    bus_valid = 1'b0; bus_write = 1'b0; src_pulse = '0;
    chk(irq_req == |(m_st & m_mk), {req, " R5 irq"}, {31'h0, irq_req},
        {31'h0, |(m_st & m_mk)});
    chk(bus_rdata == m_rd, {req, " R9 rdata"}, bus_rdata, m_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    src_pulse = '0; m_st = '0; m_mk = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(irq_req == 1'b0, "R1 irq in reset", {31'h0, irq_req}, 0);
    chk(bus_rdata == 0, "R1 rdata in reset", bus_rdata, 0);
    rst = 1'b0;
    step(1, 0, A_ST, 0, '0, "R1 status after reset");
    step(1, 0, A_MK, 0, '0, "R1 mask after reset");

    // R2: DMA source (bit 3) sets its bit, masked so no request
    step(0, 0, A_ST, 0, 11'h008, "R2 dma pulse");
    step(1, 0, A_ST, 0, '0, "R2 read pending");
    // R6: unmask already pending bit
    step(1, 1, A_MK, 32'h0000_0008, '0, "R6 unmask pending");
    chk(irq_req == 1'b1, "R6 irq raised", {31'h0, irq_req}, 1);
    // R3: AND acknowledge with ones leaves, zero clears
    step(1, 1, A_ST, 32'h0000_FFFF, '0, "R3 write ones keeps");
    step(1, 1, A_ST, 32'h0000_FFF7, '0, "R3 ack clears");
    chk(irq_req == 1'b0, "R3 irq dropped", {31'h0, irq_req}, 0);
    // R7: pulse and clearing ack in the same cycle
    step(1, 1, A_ST, 32'h0000_0000, 11'h008, "R7 set beats ack");
    step(1, 0, A_ST, 0, '0, "R7 read back");
    chk(bus_rdata == 32'h8, "R7 bit kept", bus_rdata, 32'h8);
    // R8: upper halves
    step(1, 1, A_MK, 32'hFFFF_0001, '0, "R8 mask upper ignored");
    step(1, 0, A_MK, 0, '0, "R8 read mask");
    chk(bus_rdata == 32'h1, "R8 upper zero", bus_rdata, 32'h1);
    // R4: full replace
    step(1, 1, A_MK, 32'h0000_F0F0, '0, "R4 mask replace");
    step(1, 0, A_MK, 0, '0, "R4 read mask");
    // R9: unmapped offset
    step(1, 1, A_XX, 32'hFFFF_FFFF, '0, "R9 write unmapped");
    step(1, 0, A_XX, 0, '0, "R9 read unmapped");
    step(1, 0, A_MK, 0, '0, "R9 mask untouched");
    // R10: all sources fire, upper status bits stay zero
    step(0, 0, A_ST, 0, 11'h7FF, "R10 all pulses");
    step(1, 1, A_ST, 32'h0000_FFFF, '0, "R10 ack ones");
    step(1, 0, A_ST, 0, '0, "R10 read status");
    chk(bus_rdata[15:11] == 0, "R10 spare bits", bus_rdata, {16'h0, m_st});

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      logic [11:0] a;
      logic [NSRC-1:0] p;
      k = 2'($urandom_range(0, 3));
      a = (k == 0) ? A_ST : (k == 1) ? A_MK : (k == 2) ? A_ST : A_XX;
      p = ($urandom_range(0, 3) == 0) ? 11'(1 << $urandom_range(0, NSRC-1)) : '0;
      step($urandom_range(0, 3) != 0, 1'($urandom), a, $urandom, p,
           "R2 R3 R4 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule